// File: doc/BRIEF.md
# Reference-Compare Interval Timer

This block is a 16-bit interval timer that sits on a simple register bus. Software programs a clock source, a prescale divisor and a reference value, then enables the timer. The counter advances once per prescaled tick. When it sits at the reference value on a tick, a sticky reference flag is set and, if enabled, an interrupt line goes high until software clears the flag.

Two internal clock sources are available: the system clock itself, or the system clock divided by sixteen. An 8-bit prescale field then divides the chosen source by 1 to 256. In restart mode the counter returns to zero after matching the reference. Without restart it keeps counting and wraps at the top of its range. A capture register is provided for software storage only. The bus interface uses single-cycle read and write strobes, and read data is registered.

Top module: `ref_timer`

## Requirements
- R1: After reset every register reads 0 (control at 0x00, reference at 0x04, capture at 0x08, counter at 0x0C, status at 0x11) and `irq` is low.
- R2: Control, reference and capture read back the last value written. Offsets other than the five above read 0. `bus_rdata` is loaded on the clock edge that samples `bus_rd` and then holds.
- R3: Control bit 0 enables the timer. While it is 0 the counter stays at 0, and a write to the counter offset has no effect.
- R4: A control write that changes bit 0 from 1 to 0 clears the whole control register and the reference register, whatever else the written value holds.
- R5: Control bits 2:1 pick the source: 1 is every clock, 2 is every 16th clock. With 0 or 3 the counter does not advance.
- R6: With P in control bits 15:8 and S the source period (1 or 16), one tick occurs every (P+1)*S clocks. The first tick falls (P+1)*S clocks after the edge that took a control or reference write, because any such write restarts the prescaler phase.
- R7: With control bit 3 set, a tick taken while the counter equals the reference returns the counter to 0. A reference of 0 therefore keeps the counter at 0 and sets the flag on every tick.
- R8: With control bit 3 clear, the counter passes the reference and wraps from 0xFFFF to 0x0000.
- R9: Status bit 1 is set by a tick taken while the counter equals the reference. Status bit 0 always reads 0. A status write clears each bit written as 1 and leaves the others.
- R10: `irq` is high exactly when control bit 4 and status bit 1 are both set.
- R11: While enabled, a counter write loads the written value. The load takes priority over a tick in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | 1 | Reference interrupt, level |

## Verification
The properties assume the strobes, address and write data are synchronous to `clk` and carry no unknowns once reset has gone high. They also assume a prescale or source change only reaches the tick logic through a control write, which always restarts the phase. The stimulus changes inputs only on falling edges, never raises read and write together, and disables the timer before each new timing measurement, so every counting run starts from a known phase and a zero count. Counting runs use unreachable or explicitly chosen reference values, so each expected count is a closed-form function of the idle cycles.

// File: rtl/ref_timer_pkg.sv
`timescale 1ns/1ps
package ref_timer_pkg;

  // Register byte offsets
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_CMP  = 'h04;
  localparam int OFF_CAP  = 'h08;
  localparam int OFF_CNT  = 'h0C;
  localparam int OFF_STAT = 'h11;

  // Control register field positions
  localparam int CTRL_EN      = 0;
  localparam int CTRL_SRC_LSB = 1;
  localparam int CTRL_RESTART = 3;
  localparam int CTRL_IRQ_EN  = 4;
  localparam int CTRL_PS_LSB  = 8;

  // Status register field positions
  localparam int STAT_REF = 1;

  typedef enum logic [1:0] {
    SRC_OFF0  = 2'd0,
    SRC_SYS   = 2'd1,
    SRC_SYS16 = 2'd2,
    SRC_OFF3  = 2'd3
  } src_sel_e;

endpackage

// File: rtl/rt_prescaler.sv
`timescale 1ns/1ps
module rt_prescaler
  import ref_timer_pkg::*;
#(
  parameter int PS_W   = 8,
  parameter int SDIV_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            phase_clr,
  input  src_sel_e        src,
  input  logic [PS_W-1:0] ps_val,
  output logic            tick
);

  localparam logic [SDIV_W-1:0] SDIV_LAST = '1;

  logic [SDIV_W-1:0] sdiv_q, sdiv_d;
  logic [PS_W-1:0]   pcnt_q, pcnt_d;
  logic              live;
  logic              src_tick;
  logic              ps_wrap;

  always_comb begin
    live = run & ~phase_clr;
    unique case (src)
      SRC_SYS:   src_tick = 1'b1;
      SRC_SYS16: src_tick = (sdiv_q == SDIV_LAST);
      default:   src_tick = 1'b0;
    endcase
    ps_wrap = (pcnt_q == ps_val);
    tick    = live & src_tick & ps_wrap;

    sdiv_d = sdiv_q;
    pcnt_d = pcnt_q;
    if (!live) begin
      sdiv_d = '0;
      pcnt_d = '0;
    end else begin
      if (src == SRC_SYS16) sdiv_d = sdiv_q + SDIV_W'(1);
      if (src_tick)         pcnt_d = ps_wrap ? '0 : pcnt_q + PS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sdiv_q <= '0;
      pcnt_q <= '0;
    end else begin
      sdiv_q <= sdiv_d;
      pcnt_q <= pcnt_d;
    end
  end

endmodule

// File: rtl/rt_counter.sv
`timescale 1ns/1ps
module rt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_q,
  output logic             flag_q,
  output logic             hit
);

  logic [CNT_W-1:0] cnt_d;
  logic             flag_d;

  always_comb begin
    hit = tick & (cnt_q == cmp_val);

    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (ld) begin
      cnt_d = ld_val;
    end else if (tick) begin
      cnt_d = (hit && restart) ? '0 : cnt_q + CNT_W'(1);
    end

    // a new match wins over a clear in the same cycle
    flag_d = (flag_q & ~flag_clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/rt_regs.sv
`timescale 1ns/1ps
module rt_regs
  import ref_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic [DATA_W-1:0] cap_q,
  output logic              wr_cnt,
  output logic              wr_stat,
  output logic              phase_clr
);

  logic [DATA_W-1:0] ctrl_d, cmp_d, cap_d;
  logic              wr_ctrl, wr_cmp, wr_cap;
  logic              turn_off;

  always_comb begin
    wr_ctrl   = wr & (addr == ADDR_W'(OFF_CTRL));
    wr_cmp    = wr & (addr == ADDR_W'(OFF_CMP));
    wr_cap    = wr & (addr == ADDR_W'(OFF_CAP));
    wr_cnt    = wr & (addr == ADDR_W'(OFF_CNT));
    wr_stat   = wr & (addr == ADDR_W'(OFF_STAT));
    phase_clr = wr_ctrl | wr_cmp;
    turn_off  = wr_ctrl & ctrl_q[CTRL_EN] & ~wdata[CTRL_EN];

    ctrl_d = ctrl_q;
    cmp_d  = cmp_q;
    cap_d  = cap_q;
    if (wr_ctrl) ctrl_d = turn_off ? '0 : wdata;
    if (turn_off)    cmp_d = '0;
    else if (wr_cmp) cmp_d = wdata;
    if (wr_cap) cap_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      cap_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
      cap_q  <= cap_d;
    end
  end

endmodule

// File: rtl/ref_timer.sv
`timescale 1ns/1ps
module ref_timer
  import ref_timer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 5,
  parameter int PS_W   = 8,
  parameter int SDIV_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;
  logic [DATA_W-1:0]      ctrl_q, cmp_q, cap_q, cnt_q;
  logic                   wr_cnt, wr_stat, phase_clr;
  logic                   run, restart, irq_en;
  src_sel_e               src_sel;
  logic                   tick, hit, flag_q;
  logic [DATA_W-1:0]      rd_mux;
  logic [DATA_W-1:0]      rdata_q;

  // reset: asserts asynchronously, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  rt_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_ni),
    .addr      (bus_addr),
    .wr        (bus_wr),
    .wdata     (bus_wdata),
    .ctrl_q    (ctrl_q),
    .cmp_q     (cmp_q),
    .cap_q     (cap_q),
    .wr_cnt    (wr_cnt),
    .wr_stat   (wr_stat),
    .phase_clr (phase_clr)
  );

  assign run     = ctrl_q[CTRL_EN];
  assign restart = ctrl_q[CTRL_RESTART];
  assign irq_en  = ctrl_q[CTRL_IRQ_EN];
  assign src_sel = src_sel_e'(ctrl_q[CTRL_SRC_LSB +: 2]);

  rt_prescaler #(.PS_W(PS_W), .SDIV_W(SDIV_W)) u_ps (
    .clk       (clk),
    .rst_n     (rst_ni),
    .run       (run),
    .phase_clr (phase_clr),
    .src       (src_sel),
    .ps_val    (ctrl_q[CTRL_PS_LSB +: PS_W]),
    .tick      (tick)
  );

  rt_counter #(.CNT_W(DATA_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_ni),
    .run      (run),
    .restart  (restart),
    .tick     (tick),
    .cmp_val  (cmp_q),
    .ld       (wr_cnt),
    .ld_val   (bus_wdata),
    .flag_clr (wr_stat & bus_wdata[STAT_REF]),
    .cnt_q    (cnt_q),
    .flag_q   (flag_q),
    .hit      (hit)
  );

  assign irq = irq_en & flag_q;

  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      ADDR_W'(OFF_CTRL): rd_mux = ctrl_q;
      ADDR_W'(OFF_CMP):  rd_mux = cmp_q;
      ADDR_W'(OFF_CAP):  rd_mux = cap_q;
      ADDR_W'(OFF_CNT):  rd_mux = cnt_q;
      ADDR_W'(OFF_STAT): rd_mux[STAT_REF] = flag_q;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/ref_timer_chk.sv
`timescale 1ns/1ps
module ref_timer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic [1:0]        src,
  input logic              restart,
  input logic [DATA_W-1:0] cnt,
  input logic [DATA_W-1:0] cmp_v,
  input logic              flag,
  input logic              tick,
  input logic              hit,
  input logic              ld,
  input logic              stat_wr,
  input logic              wbit_ref,
  input logic              irq
);

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  p_src_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && (src == 2'd0 || src == 2'd3) && !ld) |=> $stable(cnt));

  p_tick_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src == 2'd1 || src == 2'd2));

  p_restart_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && restart && !ld && cnt == cmp_v) |=> (cnt == '0));

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(stat_wr && wbit_ref)) |=> flag);

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wbit_ref && !hit) |=> !flag);

  p_irq_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_wr && wbit_ref && !hit) |=> !irq);

endmodule

bind ref_timer ref_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_ni),
  .run      (run),
  .src      (ctrl_q[2:1]),
  .restart  (restart),
  .cnt      (cnt_q),
  .cmp_v    (cmp_q),
  .flag     (flag_q),
  .tick     (tick),
  .hit      (hit),
  .ld       (wr_cnt),
  .stat_wr  (wr_stat),
  .wbit_ref (bus_wdata[1]),
  .irq      (irq)
);

// File: tb/sim_ref_timer.sv
`timescale 1ns/1ps
module sim_ref_timer;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_CMP  = 5'h04;
  localparam logic [4:0] A_CAP  = 5'h08;
  localparam logic [4:0] A_CNT  = 5'h0C;
  localparam logic [4:0] A_STAT = 5'h11;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;
  logic        irq;

  int          n_checks = 0;
  int          n_errors = 0;
  bit          done = 1'b0;
  logic        rd_d = 1'b0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  ref_timer u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver: queue the expected value, then issue the read
  task automatic bus_read(input logic [4:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // disable (clears control and reference), then program a reference
  task automatic stop_and_cmp(input logic [15:0] c);
    bus_write(A_CTRL, 16'h0000);
    idle(1);
    bus_write(A_CMP, c);
  endtask

  // monitor: compare data loaded by the previous read edge
  always @(posedge clk) rd_d <= bus_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) begin
        check(bus_rdata, 16'hxxxx, "scoreboard underflow");
      end else begin
        check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check({15'd0, irq}, 16'h0, "R1 irq after reset");
    bus_read(A_CTRL, 16'h0000, "R1 ctrl");
    bus_read(A_CMP,  16'h0000, "R1 ref");
    bus_read(A_CAP,  16'h0000, "R1 capture");
    bus_read(A_CNT,  16'h0000, "R1 counter");
    bus_read(A_STAT, 16'h0000, "R1 status");

    // R2 read back and undefined offsets
    bus_write(A_CMP, 16'h1234);
    bus_write(A_CAP, 16'hBEEF);
    bus_write(A_CTRL, 16'h0500);
    bus_read(A_CMP,  16'h1234, "R2 ref readback");
    bus_read(A_CAP,  16'hBEEF, "R2 capture readback");
    bus_read(A_CTRL, 16'h0500, "R2 ctrl readback");
    bus_read(5'h02,  16'h0000, "R2 hole 0x02");
    bus_read(5'h10,  16'h0000, "R2 hole 0x10");
    bus_read(5'h1F,  16'h0000, "R2 hole 0x1F");

    // R3 counter write ignored while disabled
    bus_write(A_CNT, 16'h0077);
    idle(1);
    bus_read(A_CNT, 16'h0000, "R3 load ignored when off");

    // R5 R6 system clock, divisor 1: count equals idle cycles
    bus_write(A_CMP, 16'hFFFF);
    bus_write(A_CTRL, 16'h0003);
    idle(10);
    bus_read(A_CNT, 16'd10, "R5 sys clock count");

    // R6 divisor 4 with phase restart by a reference write
    stop_and_cmp(16'hFFFF);
    bus_write(A_CTRL, 16'h030B);
    idle(2);
    bus_write(A_CMP, 16'hFFFF);
    idle(12);
    bus_read(A_CNT, 16'd3, "R6 divisor 4 phase restart");

    // R5 R6 clock/16 and divisor 2: period 32
    stop_and_cmp(16'hFFFF);
    bus_write(A_CTRL, 16'h010D);
    idle(100);
    bus_read(A_CNT, 16'd3, "R5 clock/16 count");

    // R5 unsupported sources do not count
    stop_and_cmp(16'hFFFF);
    bus_write(A_CTRL, 16'h0009);
    idle(20);
    bus_read(A_CNT, 16'd0, "R5 source 0 idle");
    bus_write(A_CTRL, 16'h000F);
    idle(20);
    bus_read(A_CNT, 16'd0, "R5 source 3 idle");

    // R4 turning off clears control and reference
    bus_write(A_CTRL, 16'h1230);
    idle(1);
    bus_read(A_CTRL, 16'h0000, "R4 ctrl cleared");
    bus_read(A_CMP,  16'h0000, "R4 ref cleared");

    // R7 R9 R10 restart at reference 4, interrupt enabled
    bus_write(A_CMP, 16'd4);
    bus_write(A_CTRL, 16'h001B);
    idle(3);
    bus_read(A_CNT,  16'd3,    "R7 count before match");
    bus_read(A_STAT, 16'h0000, "R9 flag not yet set");
    bus_read(A_STAT, 16'h0002, "R9 flag set on match");
    check({15'd0, irq}, 16'h1, "R10 irq with flag and enable");
    bus_read(A_CNT,  16'd1,    "R7 count restarted");

    // R9 write-one-to-clear, counting stopped via source 0
    bus_write(A_CTRL, 16'h0019);
    bus_write(A_STAT, 16'h0001);
    bus_read(A_STAT, 16'h0002, "R9 bit0 write keeps flag");
    bus_write(A_STAT, 16'hFFFD);
    bus_read(A_STAT, 16'h0002, "R9 zero bit keeps flag");
    check({15'd0, irq}, 16'h1, "R10 irq still high");
    bus_write(A_STAT, 16'h0002);
    check({15'd0, irq}, 16'h0, "R10 irq low after clear");
    bus_read(A_STAT, 16'h0000, "R9 flag cleared");

    // R7 reference zero, R10 gating without enable
    stop_and_cmp(16'h0000);
    bus_write(A_CTRL, 16'h000B);
    idle(3);
    bus_read(A_CNT,  16'd0,    "R7 zero reference holds count");
    bus_read(A_STAT, 16'h0002, "R7 zero reference sets flag");
    check({15'd0, irq}, 16'h0, "R10 irq masked by enable");

    // R11 load, R8 wrap without restart
    bus_write(A_CTRL, 16'h0001);
    bus_write(A_CMP, 16'd3);
    bus_write(A_CNT, 16'hFFFE);
    bus_write(A_STAT, 16'h0002);
    bus_read(A_CNT, 16'hFFFE, "R11 counter load");
    bus_write(A_CTRL, 16'h0003);
    bus_read(A_CNT,  16'hFFFE, "R8 run from load");
    bus_read(A_CNT,  16'hFFFF, "R8 top value");
    bus_read(A_CNT,  16'h0000, "R8 wrap to zero");
    bus_read(A_CNT,  16'h0001, "R8 after wrap");
    bus_read(A_CNT,  16'h0002, "R8 before match");
    bus_read(A_CNT,  16'h0003, "R8 at match");
    bus_read(A_STAT, 16'h0002, "R9 flag from free run match");
    bus_read(A_CNT,  16'h0005, "R8 passes reference");

    idle(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule